// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block is a memory-mapped event timer built around one 64-bit free-running main counter and a parameterised set of comparator channels (three by default). Each channel compares the counter against its own target and, on an exact hit, raises an event. The event appears as a one-cycle pulse or a held status bit on a selectable interrupt line, or as a message write that carries an address and a data word. A channel may run once or reload itself periodically by adding a programmed period to its target after each hit.

Software reaches the block through a single-cycle 32-bit register bus with a combinational read path. The global registers are a capability word, a read-only tick period in femtoseconds, a global control word (run, legacy routing), a write-one-to-clear status word and the counter as two halves. Each channel has a 32-byte window holding its control word, the comparator halves and the two message words. Comparator writes pass through a short internal pipeline before they reach the compare logic. When legacy routing is turned on, channels 0 and 1 move off the general interrupt lines onto two dedicated legacy outputs.

Top module: `evt_tmr`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the global control and status words read 0, and every interrupt, legacy and message output is low.
- R2: The capability word at 0x00 reads bits [7:0] = number of channels minus one, bit 8 = legacy routing supported, bit 9 = 64-bit counter; the word at 0x04 returns the PERIOD_FS parameter.
- R3: While global control bit 0 (run) is set the counter rises by exactly one per clock and writes to its halves (0x10 low, 0x14 high) are ignored; while run is clear it holds its value and accepts those writes.
- R4: A channel hits only in a cycle where run is set and the counter equals its comparator exactly; a target the counter has already passed does not hit until the counter comes round to it again.
- R5: With channel control bit 4 (force-32) set, only the low 32 bits of counter and comparator are compared and the periodic add wraps within the low 32 bits; otherwise all 64 bits are compared.
- R6: A write to a channel's comparator low word (offset 0x04; offset 0x08 first stages the high word) takes part in comparison exactly WR_DELAY clocks after the write edge; a target reached before then is missed.
- R7: When channel control bits 1 (periodic) and 8 (set-value) are both set, the next comparator write loads the target and clears bit 8; each later comparator write loads the period, and every hit then adds the period to the target.
- R8: In edge mode (control bit 5 clear) a hit with control bit 0 (interrupt enable) set drives a single-cycle pulse, one clock after the hit, on interrupt line irq_out[route], where route is control bits [12:9].
- R9: In level mode (control bit 5 set) a hit with interrupt enable sets the channel's bit in the status word at 0x0C and holds the routed line high until software writes 1 to that bit.
- R10: With control bit 6 (message enable) set, a hit produces a one-cycle message strobe for that channel carrying the data word (offset 0x10) and address word (offset 0x14), and the channel drives no interrupt line.
- R11: With global control bit 1 (legacy) set, channels 0 and 1 drive legacy_irq[0] and legacy_irq[1] instead of their routed lines.
- R12: With interrupt enable clear, a hit produces no pulse, no status bit and no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | NIRQ | General interrupt lines |
| legacy_irq | output | 2 | Dedicated legacy lines for channels 0 and 1 |
| msg_valid | output | NCH | Per-channel message strobe |
| msg_addr | output | NCH*32 | Per-channel message address, channel c in bits [32c+31:32c] |
| msg_data | output | NCH*32 | Per-channel message data, channel c in bits [32c+31:32c] |

## Verification
A wrong comparator or period value shows up as an event at the wrong count, and because a target that is passed is not recovered, an off-by-one in the write pipeline or the periodic add turns into a missing pulse instead of a late one. The checks therefore record the exact cycle of each event relative to the start of counting, so that a one-clock error in the delay, the set-value sequence or the 32-bit wrap is visible on the first event. A stale status bit or route field shows on the next hit as a line that stays high or one that fires on the wrong output.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    // channel control word bit positions
    localparam int CFG_IRQ_EN    = 0;
    localparam int CFG_PERIODIC  = 1;
    localparam int CFG_PER_CAP   = 2;
    localparam int CFG_WIDE_CAP  = 3;
    localparam int CFG_FORCE32   = 4;
    localparam int CFG_LEVEL     = 5;
    localparam int CFG_MSG_EN    = 6;
    localparam int CFG_MSG_CAP   = 7;
    localparam int CFG_SETVAL    = 8;
    localparam int CFG_ROUTE_LSB = 9;
    localparam int ROUTE_FIELD_W = 4;

    // global register addresses
    localparam logic [7:0] A_CAP    = 8'h00;
    localparam logic [7:0] A_PERIOD = 8'h04;
    localparam logic [7:0] A_GCFG   = 8'h08;
    localparam logic [7:0] A_STATUS = 8'h0C;
    localparam logic [7:0] A_CNT_LO = 8'h10;
    localparam logic [7:0] A_CNT_HI = 8'h14;

    // channel windows: addr[7:5] == channel + CH_BASE_IDX
    localparam int CH_BASE_IDX = 2;
    localparam logic [4:0] O_CFG      = 5'h00;
    localparam logic [4:0] O_CMP_LO   = 5'h04;
    localparam logic [4:0] O_CMP_HI   = 5'h08;
    localparam logic [4:0] O_MSG_DATA = 5'h10;
    localparam logic [4:0] O_MSG_ADDR = 5'h14;

    typedef enum logic {
        LD_MATCH  = 1'b0,
        LD_PERIOD = 1'b1
    } load_kind_e;

    typedef struct packed {
        logic       vld;
        load_kind_e kind;
        logic [63:0] val;
    } cmp_load_t;

    typedef struct packed {
        logic [ROUTE_FIELD_W-1:0] route;
        logic setval;
        logic msg_en;
        logic level;
        logic force32;
        logic periodic;
        logic irq_en;
    } ch_cfg_t;

    typedef struct packed {
        ch_cfg_t     cfg;
        logic [63:0] cmp;
        logic [63:0] per;
        logic [31:0] hi_hold;
        logic        status;
        logic        pulse;
        logic        msg_v;
        logic [31:0] mdata;
        logic [31:0] maddr;
    } ch_state_t;

    typedef struct packed {
        logic run;
        logic legacy;
    } gcfg_t;

endpackage

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] cnt
);
    localparam int HI_W = CW - 32;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) begin
            cnt_d = cnt_q + CW'(1);
        end else begin
            if (lo_we) cnt_d[31:0] = wdata;
            if (hi_we) cnt_d[CW-1:32] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !lo_we && !hi_we) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
    import evt_tmr_pkg::*;
#(
    parameter int WR_DELAY = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [63:0]              cnt,
    input  logic                     run,
    input  logic                     cfg_we,
    input  logic                     cmp_lo_we,
    input  logic                     cmp_hi_we,
    input  logic                     mdata_we,
    input  logic                     maddr_we,
    input  logic                     sts_clr,
    input  logic [31:0]              wdata,
    output logic [31:0]              cfg_rd,
    output logic [63:0]              cmp_rd,
    output logic [31:0]              mdata,
    output logic [31:0]              maddr,
    output logic [ROUTE_FIELD_W-1:0] route,
    output logic                     int_out,
    output logic                     status,
    output logic                     msg_fire
);
    localparam int DLY = (WR_DELAY < 1) ? 1 : WR_DELAY;

    ch_state_t s_d, s_q;
    cmp_load_t pipe_d [DLY];
    cmp_load_t pipe_q [DLY];

    logic        match_c;
    logic        fire_c;
    logic [63:0] adv_cmp;
    cmp_load_t   landing;

    // comparator write pipeline
    always_comb begin
        pipe_d[0].vld  = cmp_lo_we;
        pipe_d[0].kind = (s_q.cfg.periodic && !s_q.cfg.setval) ? LD_PERIOD : LD_MATCH;
        pipe_d[0].val  = {s_q.hi_hold, wdata};
        for (int k = 1; k < DLY; k++) pipe_d[k] = pipe_q[k-1];
    end

    assign landing = pipe_q[DLY-1];

    always_comb begin
        match_c = run && (s_q.cfg.force32 ? (cnt[31:0] == s_q.cmp[31:0])
                                           : (cnt == s_q.cmp));
        fire_c  = match_c && s_q.cfg.irq_en;
        adv_cmp = s_q.cfg.force32 ? {s_q.cmp[63:32], s_q.cmp[31:0] + s_q.per[31:0]}
                                  : s_q.cmp + s_q.per;

        s_d = s_q;

        if (cfg_we) begin
            s_d.cfg.irq_en   = wdata[CFG_IRQ_EN];
            s_d.cfg.periodic = wdata[CFG_PERIODIC];
            s_d.cfg.force32  = wdata[CFG_FORCE32];
            s_d.cfg.level    = wdata[CFG_LEVEL];
            s_d.cfg.msg_en   = wdata[CFG_MSG_EN];
            s_d.cfg.setval   = wdata[CFG_SETVAL];
            s_d.cfg.route    = wdata[CFG_ROUTE_LSB +: ROUTE_FIELD_W];
        end
        if (cmp_hi_we) s_d.hi_hold = wdata;
        if (cmp_lo_we && s_q.cfg.setval) s_d.cfg.setval = 1'b0;
        if (mdata_we) s_d.mdata = wdata;
        if (maddr_we) s_d.maddr = wdata;

        if (match_c && s_q.cfg.periodic) s_d.cmp = adv_cmp;
        if (landing.vld) begin
            if (landing.kind == LD_MATCH) s_d.cmp = landing.val;
            else                          s_d.per = landing.val;
        end

        s_d.pulse = fire_c && !s_q.cfg.level && !s_q.cfg.msg_en;
        s_d.msg_v = fire_c && s_q.cfg.msg_en;
        if (sts_clr) s_d.status = 1'b0;
        if (fire_c && s_q.cfg.level) s_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int k = 0; k < DLY; k++) pipe_q[k] <= '0;
        end else begin
            s_q <= s_d;
            for (int k = 0; k < DLY; k++) pipe_q[k] <= pipe_d[k];
        end
    end

    always_comb begin
        cfg_rd = '0;
        cfg_rd[CFG_IRQ_EN]   = s_q.cfg.irq_en;
        cfg_rd[CFG_PERIODIC] = s_q.cfg.periodic;
        cfg_rd[CFG_PER_CAP]  = 1'b1;
        cfg_rd[CFG_WIDE_CAP] = 1'b1;
        cfg_rd[CFG_FORCE32]  = s_q.cfg.force32;
        cfg_rd[CFG_LEVEL]    = s_q.cfg.level;
        cfg_rd[CFG_MSG_EN]   = s_q.cfg.msg_en;
        cfg_rd[CFG_MSG_CAP]  = 1'b1;
        cfg_rd[CFG_SETVAL]   = s_q.cfg.setval;
        cfg_rd[CFG_ROUTE_LSB +: ROUTE_FIELD_W] = s_q.cfg.route;
    end

    assign cmp_rd   = s_q.cmp;
    assign mdata    = s_q.mdata;
    assign maddr    = s_q.maddr;
    assign route    = s_q.cfg.route;
    assign status   = s_q.status;
    assign msg_fire = s_q.msg_v;
    assign int_out  = !s_q.cfg.msg_en && (s_q.cfg.level ? s_q.status : s_q.pulse);

    // R8
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |-> $past(match_c));

    // R9
    status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.status) |-> $past(match_c && s_q.cfg.level && s_q.cfg.irq_en));

    // R7
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cfg.setval && cmp_lo_we) |=> !s_q.cfg.setval);

    // R10
    msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.msg_v |-> $past(match_c && s_q.cfg.irq_en && s_q.cfg.msg_en));

endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
    import evt_tmr_pkg::*;
#(
    parameter int          NCH        = 3,
    parameter int          NIRQ       = 8,
    parameter int          WR_DELAY   = 2,
    parameter logic [31:0] PERIOD_FS  = 32'd69841279,
    parameter bit          LEGACY_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NIRQ-1:0]   irq_out,
    output logic [1:0]        legacy_irq,
    output logic [NCH-1:0]    msg_valid,
    output logic [NCH*32-1:0] msg_addr,
    output logic [NCH*32-1:0] msg_data
);
    localparam int CNT_W = 64;
    localparam logic [31:0] CAP_WORD = {22'd0, 1'b1, LEGACY_CAP, 8'(NCH - 1)};

    gcfg_t gcfg_d, gcfg_q;

    logic             we;
    logic [4:0]       off;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   ch_sel;
    logic [NCH-1:0]   ch_int;
    logic [NCH-1:0]   ch_status;
    logic [31:0]      ch_cfg_rd [NCH];
    logic [63:0]      ch_cmp_rd [NCH];
    logic [31:0]      ch_mdata  [NCH];
    logic [31:0]      ch_maddr  [NCH];
    logic [ROUTE_FIELD_W-1:0] ch_route [NCH];

    assign we  = bus_sel && bus_wr;
    assign off = bus_addr[4:0];

    always_comb begin
        gcfg_d = gcfg_q;
        if (we && bus_addr == A_GCFG) begin
            gcfg_d.run    = bus_wdata[0];
            gcfg_d.legacy = bus_wdata[1] && LEGACY_CAP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gcfg_q <= '0;
        else        gcfg_q <= gcfg_d;
    end

    evt_tmr_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gcfg_q.run),
        .lo_we (we && bus_addr == A_CNT_LO && !gcfg_q.run),
        .hi_we (we && bus_addr == A_CNT_HI && !gcfg_q.run),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_sel[c] = bus_addr[7:5] == 3'(c + CH_BASE_IDX);

        evt_tmr_chan #(.WR_DELAY(WR_DELAY)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .run       (gcfg_q.run),
            .cfg_we    (we && ch_sel[c] && off == O_CFG),
            .cmp_lo_we (we && ch_sel[c] && off == O_CMP_LO),
            .cmp_hi_we (we && ch_sel[c] && off == O_CMP_HI),
            .mdata_we  (we && ch_sel[c] && off == O_MSG_DATA),
            .maddr_we  (we && ch_sel[c] && off == O_MSG_ADDR),
            .sts_clr   (we && bus_addr == A_STATUS && bus_wdata[c]),
            .wdata     (bus_wdata),
            .cfg_rd    (ch_cfg_rd[c]),
            .cmp_rd    (ch_cmp_rd[c]),
            .mdata     (ch_mdata[c]),
            .maddr     (ch_maddr[c]),
            .route     (ch_route[c]),
            .int_out   (ch_int[c]),
            .status    (ch_status[c]),
            .msg_fire  (msg_valid[c])
        );

        assign msg_data[c*32 +: 32] = ch_mdata[c];
        assign msg_addr[c*32 +: 32] = ch_maddr[c];
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CAP:    bus_rdata = CAP_WORD;
            A_PERIOD: bus_rdata = PERIOD_FS;
            A_GCFG:   bus_rdata = {30'd0, gcfg_q.legacy, gcfg_q.run};
            A_STATUS: bus_rdata[NCH-1:0] = ch_status;
            A_CNT_LO: bus_rdata = cnt[31:0];
            A_CNT_HI: bus_rdata = cnt[63:32];
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (ch_sel[c]) begin
                        case (off)
                            O_CFG:      bus_rdata = ch_cfg_rd[c];
                            O_CMP_LO:   bus_rdata = ch_cmp_rd[c][31:0];
                            O_CMP_HI:   bus_rdata = ch_cmp_rd[c][63:32];
                            O_MSG_DATA: bus_rdata = ch_mdata[c];
                            O_MSG_ADDR: bus_rdata = ch_maddr[c];
                            default:    bus_rdata = '0;
                        endcase
                    end
                end
            end
        endcase
    end

    // interrupt routing with legacy override of channels 0 and 1
    always_comb begin
        irq_out    = '0;
        legacy_irq = '0;
        for (int c = 0; c < NCH; c++) begin
            if (gcfg_q.legacy && c < 2) begin
                legacy_irq[c] = ch_int[c];
            end else begin
                for (int r = 0; r < NIRQ; r++) begin
                    if (ch_route[c] == ROUTE_FIELD_W'(r))
                        irq_out[r] = irq_out[r] | ch_int[c];
                end
            end
        end
    end

    // R11
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gcfg_q.legacy |-> (legacy_irq == 2'b00));

endmodule

// File: tb/evt_tmr_test.sv
`timescale 1ns/1ps
module evt_tmr_test;
    localparam int NCH  = 3;
    localparam int NIRQ = 8;
    localparam int D    = 2;
    localparam logic [31:0] PFS = 32'd69841279;

    localparam logic [7:0] GCFG = 8'h08, STS = 8'h0C, CLO = 8'h10, CHI = 8'h14, CAPR = 8'h00, PERR = 8'h04;
    localparam logic [7:0] C0 = 8'h40, C1 = 8'h60, C2 = 8'h80;
    localparam logic [7:0] OCFG = 8'h00, OCL = 8'h04, OCH = 8'h08, OMD = 8'h10, OMA = 8'h14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NIRQ-1:0] irq_out;
    logic [1:0] legacy_irq;
    logic [NCH-1:0] msg_valid;
    logic [NCH*32-1:0] msg_addr, msg_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    evt_tmr #(.NCH(NCH), .NIRQ(NIRQ), .WR_DELAY(D), .PERIOD_FS(PFS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .legacy_irq(legacy_irq), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data));

    typedef struct packed {
        logic [31:0] start;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        f32;
        logic [7:0]  exp;   // sample index of the pulse, FF = none
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h0,        32'h0, 32'd5,  1'b0, 8'd6},
        '{32'h0,        32'h0, 32'd0,  1'b0, 8'd1},
        '{32'h0,        32'h0, 32'd37, 1'b0, 8'd38},
        '{32'hFFFFFFF0, 32'h0, 32'd5,  1'b1, 8'd22},
        '{32'hFFFFFFF0, 32'h0, 32'd5,  1'b0, 8'hFF},
        '{32'hFFFFFFF0, 32'h1, 32'd5,  1'b0, 8'd22},
        '{32'd100,      32'h0, 32'd50, 1'b0, 8'hFF},
        '{32'h0,        32'h1, 32'd7,  1'b1, 8'd8},
        '{32'h0,        32'h1, 32'd7,  1'b0, 8'hFF}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic restart();
        wr(GCFG, 32'h0);
        wr(CLO, 32'h0);
        wr(CHI, 32'h0);
    endtask

    function automatic logic probe_bit(input int p);
        if (p < NIRQ) return irq_out[p];
        if (p < NIRQ + 2) return legacy_irq[p - NIRQ];
        return msg_valid[p - NIRQ - 2];
    endfunction

    // sample index i is the cycle in which the counter has advanced i times since start
    task automatic scan(input int n, input int p, input int widx, input logic [7:0] wa,
                        input logic [31:0] wd, output int hits, output int t0,
                        output int t1, output int t2, output int gen_hits);
        hits = 0; t0 = -1; t1 = -1; t2 = -1; gen_hits = 0;
        for (int i = 0; i < n; i++) begin
            if (probe_bit(p)) begin
                if (hits == 0) t0 = i;
                else if (hits == 1) t1 = i;
                else if (hits == 2) t2 = i;
                hits++;
            end
            if (irq_out != '0) gen_hits++;
            if (i == widx) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = wa; bus_wdata = wd;
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int h, a0, a1, a2, g;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        repeat (4) @(negedge clk);
        rd(CLO, r);  chk("R1", "counter low after reset", r, 0);
        rd(CHI, r);  chk("R1", "counter high after reset", r, 0);
        rd(GCFG, r); chk("R1", "global control after reset", r, 0);
        rd(STS, r);  chk("R1", "status after reset", r, 0);
        chk("R1", "output lines after reset", {irq_out, legacy_irq, msg_valid}, 0);

        // R2 identification
        rd(CAPR, r); chk("R2", "capability word", r, 32'h302);
        rd(PERR, r); chk("R2", "period word", r, PFS);

        // R3 counting, stop, writes
        restart();
        wr(GCFG, 32'h1);
        rd(CLO, r); chk("R3", "count one cycle after start", r, 1);
        repeat (9) @(negedge clk);
        rd(CLO, r); chk("R3", "count eleven cycles after start", r, 11);
        wr(CLO, 32'h1234);
        rd(CLO, r); chk("R3", "counter write ignored while running", r, 14);
        wr(GCFG, 32'h0);
        rd(CLO, r); chk("R3", "counter holds when stopped", r, 16);
        wr(CLO, 32'hABCD);
        wr(CHI, 32'h5);
        rd(CLO, r); chk("R3", "low half written while stopped", r, 32'hABCD);
        rd(CHI, r); chk("R3", "high half written while stopped", r, 5);

        // R4 R5 R8 table: channel 0, edge mode, route 1
        for (int v = 0; v < NV; v++) begin
            restart();
            wr(CLO, VEC[v].start);
            wr(C0 + OCFG, 32'h201 | (32'(VEC[v].f32) << 4));
            wr(C0 + OCH, VEC[v].hi);
            wr(C0 + OCL, VEC[v].lo);
            repeat (D + 2) @(negedge clk);
            wr(GCFG, 32'h1);
            scan(60, 1, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
            chk(VEC[v].f32 ? "R5" : "R4", $sformatf("vector %0d pulse index", v),
                64'(a0), (VEC[v].exp == 8'hFF) ? 64'(-1) : 64'(int'(VEC[v].exp)));
            chk("R8", $sformatf("vector %0d single-cycle pulse count", v),
                64'(h), (VEC[v].exp == 8'hFF) ? 64'd0 : 64'd1);
        end

        // R6 comparator write delay: hit exactly at D clocks
        restart();
        wr(C0 + OCH, 32'h0);
        wr(C0 + OCL, 32'hFFFF);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(40, 1, 10, C0 + OCL, 32'(10 + 1 + D), h, a0, a1, a2, g);
        chk("R6", "target just reachable after delay", 64'(a0), 64'(10 + D + 2));
        restart();
        wr(C0 + OCL, 32'hFFFF);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(40, 1, 10, C0 + OCL, 32'(10 + D), h, a0, a1, a2, g);
        chk("R6", "target reached inside delay is missed", 64'(h), 0);

        // R7 periodic with set-value: target 4, period 10, route 3
        restart();
        wr(C1 + OCFG, 32'h1 | 32'h2 | 32'h100 | (32'd3 << 9));
        wr(C1 + OCH, 32'h0);
        wr(C1 + OCL, 32'd4);
        wr(C1 + OCL, 32'd10);
        rd(C1 + OCFG, r); chk("R7", "set-value cleared, capability bits read 1", r, 32'h68F);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(40, 3, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
        chk("R7", "first periodic hit", 64'(a0), 5);
        chk("R7", "second periodic hit", 64'(a1), 15);
        chk("R7", "third periodic hit", 64'(a2), 25);
        chk("R7", "periodic hit count", 64'(h), 4);
        wr(C1 + OCFG, 32'h0);

        // R9 level mode: channel 2, route 5, target 3
        restart();
        wr(C2 + OCFG, 32'h1 | 32'h20 | (32'd5 << 9));
        wr(C2 + OCH, 32'h0);
        wr(C2 + OCL, 32'd3);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(10, 5, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
        chk("R9", "level line rises one clock after hit", 64'(a0), 4);
        chk("R9", "level line held", 64'(h), 6);
        rd(STS, r); chk("R9", "status bit set", r, 32'h4);
        wr(STS, 32'h4);
        chk("R9", "line low after clear", 64'(irq_out[5]), 0);
        rd(STS, r); chk("R9", "status bit cleared", r, 0);

        // R12 interrupt enable clear
        restart();
        wr(C2 + OCFG, 32'h20 | (32'd5 << 9));
        wr(C2 + OCL, 32'd3);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(10, 5, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
        chk("R12", "no line when disabled", 64'(h), 0);
        rd(STS, r); chk("R12", "no status when disabled", r, 0);

        // R10 message delivery on channel 0
        restart();
        wr(C0 + OCFG, 32'h1 | 32'h40 | (32'd1 << 9));
        wr(C0 + OMD, 32'hCAFE0001);
        wr(C0 + OMA, 32'hFEE00010);
        wr(C0 + OCH, 32'h0);
        wr(C0 + OCL, 32'd8);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h1);
        scan(20, NIRQ + 2, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
        chk("R10", "message strobe index", 64'(a0), 9);
        chk("R10", "message strobe count", 64'(h), 1);
        chk("R10", "no interrupt line in message mode", 64'(g), 0);
        chk("R10", "message data word", msg_data[31:0], 32'hCAFE0001);
        chk("R10", "message address word", msg_addr[31:0], 32'hFEE00010);

        // R11 legacy routing of channel 0
        restart();
        wr(C0 + OCFG, 32'h1 | (32'd1 << 9));
        wr(C0 + OCL, 32'd6);
        repeat (D + 2) @(negedge clk);
        wr(GCFG, 32'h3);
        scan(20, NIRQ, -1, 8'h0, 32'h0, h, a0, a1, a2, g);
        chk("R11", "legacy line pulse index", 64'(a0), 7);
        chk("R11", "legacy line pulse count", 64'(h), 1);
        chk("R11", "routed line silent under legacy", 64'(g), 0);
        wr(GCFG, 32'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule